// File: doc/BRIEF.md
# Three-Core Bank Controller Switch

This block sits between a console's CPU bus and three bank-switching controller cores on one cartridge: a latch-register core with mirrored register windows, a scanline-counting core with an interrupt, and a serially loaded core. Only one core is electrically attached at a time. A small supervisor register, written by the CPU in the $4000-$7FFF window, picks the attached core. It also supplies a pattern-memory (CHR) base bit that offsets the pattern address by 256 KiB.

The switch gates CPU write strobes in $8000-$FFFF so that they reach the selected core alone. Cores that are not selected keep their contents and cannot be reprogrammed until they are selected again. Only the selected core's program address, pattern address and interrupt request are passed on; the others are hidden. A supervisor write whose address has bit 0 set also sends a one-cycle reset pulse to the serially loaded core. The $6000-$7FFF range decodes no work RAM, because the supervisor owns that window.

Top module: `tri_mapper_router`

## Requirements
- R1: After reset the supervisor register is zero: the latch core is selected, the base bit is 0, no core write enable is high and the soft-reset pulse is low.
- R2: A write loads the supervisor register only when address bits [15:14] are 01 and address bit 8 is 1 (for example $4100, $5100, $41FF, $7FFF). Writes to $4000, $6000 or any other address leave it unchanged.
- R3: In a supervisor write, data bit 2 becomes the base bit and data bits [1:0] become the mode field. Data bits [7:3] have no effect.
- R4: Mode 00 selects the latch core, mode 01 selects the scanline core, and modes 10 and 11 both select the serial core.
- R5: A CPU write with address bit 15 set raises, in the same cycle, the write enable of the selected core only. No enable rises for a write below $8000.
- R6: The program and pattern address outputs carry the selected core's addresses. A core that is not selected keeps the value last written to it.
- R7: The interrupt output follows only the selected core's interrupt request.
- R8: While the latch core or the scanline core is selected, pattern address bit 18 equals the base bit.
- R9: While the serial core is selected, pattern address bit 18 comes from bit 18 of that core's own pattern address, and the base bit is ignored. A parameter makes bit 18 follow the base bit instead.
- R10: A decoded supervisor write with address bit 0 set drives the serial-core soft reset high for exactly the one cycle after the write. A write with address bit 0 clear never drives it.
- R11: A new mode or base value reaches the outputs in the cycle after the supervisor write. During the write cycle the outputs still reflect the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| latch_we | output | 1 | Write enable to the latch core |
| scan_we | output | 1 | Write enable to the scanline core |
| serial_we | output | 1 | Write enable to the serial core |
| serial_soft_rst | output | 1 | One-cycle reset pulse to the serial core |
| latch_prg | input | 19 | Latch core program address |
| latch_chr | input | 18 | Latch core pattern address, bits 17:0 |
| latch_irq | input | 1 | Latch core interrupt request |
| scan_prg | input | 19 | Scanline core program address |
| scan_chr | input | 18 | Scanline core pattern address, bits 17:0 |
| scan_irq | input | 1 | Scanline core interrupt request |
| serial_prg | input | 19 | Serial core program address |
| serial_chr | input | 19 | Serial core pattern address, bits 18:0 |
| serial_irq | input | 1 | Serial core interrupt request |
| prg_addr | output | 19 | Routed program address |
| chr_addr | output | 19 | Routed pattern address, bit 18 from base or serial core |
| irq_out | output | 1 | Routed interrupt request |

## Verification
The checker enforces on every cycle that at most one core write enable is high, and only for a $8000-$FFFF write to the core the mode field selects. It also enforces that the interrupt and pattern bit 18 follow the selected source, that the soft-reset pulse lasts one cycle and always has a qualifying write behind it, and that the register holds when no decoded write occurs. Only the bench scenarios can show that data bits 2:0 land in the intended fields, that mirrored and undecoded addresses behave correctly, that a deselected core keeps its contents across mode switches, and the exact cycle in which a mode change becomes visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CORES = 3;

    typedef enum logic [1:0] {
        SEL_LATCH  = 2'd0,
        SEL_SCAN   = 2'd1,
        SEL_SERIAL = 2'd2
    } core_sel_e;

    typedef struct packed {
        logic       base;
        logic [1:0] mode;
    } sup_reg_t;

    typedef struct packed {
        sup_reg_t r;
        logic     pulse;
    } sup_state_t;

    function automatic core_sel_e mode_to_sel(input logic [1:0] mode);
        core_sel_e s;
        case (mode)
            2'b00:   s = SEL_LATCH;
            2'b01:   s = SEL_SCAN;
            default: s = SEL_SERIAL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int ADDR_W  = 16,
    parameter int SEL_BIT = 8
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    output logic              sup_hit,
    output logic              rom_hit,
    output logic              soft_req
);
    logic unused_addr;

    always_comb begin
        // supervisor window: top two bits 01 and the match bit set
        sup_hit  = cpu_wr && (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b01) && cpu_addr[SEL_BIT];
        rom_hit  = cpu_wr && cpu_addr[ADDR_W-1];
        soft_req = cpu_addr[0];
    end

    assign unused_addr = ^{cpu_addr[ADDR_W-3:SEL_BIT+1], cpu_addr[SEL_BIT-1:1]};

endmodule

// File: rtl/tmr_supervisor.sv
module tmr_supervisor
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_hit,
    input  logic              soft_req,
    input  logic [DATA_W-1:0] cpu_data,
    output sup_reg_t          reg_q,
    output logic              soft_rst
);
    sup_state_t st_d, st_q;
    logic       unused_data;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (sup_hit) begin
            st_d.r.base = cpu_data[2];
            st_d.r.mode = cpu_data[1:0];
            st_d.pulse  = soft_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_q       = st_q.r;
    assign soft_rst    = st_q.pulse;
    assign unused_data = ^cpu_data[DATA_W-1:3];

endmodule

// File: rtl/tmr_wr_gate.sv
module tmr_wr_gate
    import tmr_pkg::*;
(
    input  logic                 rom_hit,
    input  core_sel_e            sel,
    output logic [NUM_CORES-1:0] we
);
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_we
        localparam logic [1:0] IDX = 2'(i);
        assign we[i] = rom_hit && (2'(sel) == IDX);
    end

endmodule

// File: rtl/tmr_route.sv
module tmr_route
    import tmr_pkg::*;
#(
    parameter int PRG_W           = 19,
    parameter int CHR_LO_W        = 18,
    parameter bit A18_FROM_SERIAL = 1'b1
) (
    input  core_sel_e           sel,
    input  logic                base,
    input  logic [PRG_W-1:0]    latch_prg,
    input  logic [CHR_LO_W-1:0] latch_chr,
    input  logic                latch_irq,
    input  logic [PRG_W-1:0]    scan_prg,
    input  logic [CHR_LO_W-1:0] scan_chr,
    input  logic                scan_irq,
    input  logic [PRG_W-1:0]    serial_prg,
    input  logic [CHR_LO_W:0]   serial_chr,
    input  logic                serial_irq,
    output logic [PRG_W-1:0]    prg_addr,
    output logic [CHR_LO_W:0]   chr_addr,
    output logic                irq_out
);
    always_comb begin
        case (sel)
            SEL_LATCH: begin
                prg_addr                = latch_prg;
                chr_addr[CHR_LO_W-1:0]  = latch_chr;
                irq_out                 = latch_irq;
            end
            SEL_SCAN: begin
                prg_addr                = scan_prg;
                chr_addr[CHR_LO_W-1:0]  = scan_chr;
                irq_out                 = scan_irq;
            end
            default: begin
                prg_addr                = serial_prg;
                chr_addr[CHR_LO_W-1:0]  = serial_chr[CHR_LO_W-1:0];
                irq_out                 = serial_irq;
            end
        endcase
    end

    if (A18_FROM_SERIAL) begin : g_top_serial
        assign chr_addr[CHR_LO_W] = (sel == SEL_SERIAL) ? serial_chr[CHR_LO_W] : base;
    end else begin : g_top_base
        logic unused_serial_top;
        assign chr_addr[CHR_LO_W] = base;
        assign unused_serial_top  = serial_chr[CHR_LO_W];
    end

endmodule

// File: rtl/tri_mapper_router.sv
module tri_mapper_router
    import tmr_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter int DATA_W          = 8,
    parameter int PRG_W           = 19,
    parameter int CHR_LO_W        = 18,
    parameter int SEL_BIT         = 8,
    parameter bit A18_FROM_SERIAL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_data,
    input  logic                cpu_wr,
    output logic                latch_we,
    output logic                scan_we,
    output logic                serial_we,
    output logic                serial_soft_rst,
    input  logic [PRG_W-1:0]    latch_prg,
    input  logic [CHR_LO_W-1:0] latch_chr,
    input  logic                latch_irq,
    input  logic [PRG_W-1:0]    scan_prg,
    input  logic [CHR_LO_W-1:0] scan_chr,
    input  logic                scan_irq,
    input  logic [PRG_W-1:0]    serial_prg,
    input  logic [CHR_LO_W:0]   serial_chr,
    input  logic                serial_irq,
    output logic [PRG_W-1:0]    prg_addr,
    output logic [CHR_LO_W:0]   chr_addr,
    output logic                irq_out
);
    logic                 sup_hit;
    logic                 rom_hit;
    logic                 soft_req;
    sup_reg_t             sup_q;
    core_sel_e            sel;
    logic [NUM_CORES-1:0] we;

    tmr_decode #(
        .ADDR_W  (ADDR_W),
        .SEL_BIT (SEL_BIT)
    ) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .sup_hit  (sup_hit),
        .rom_hit  (rom_hit),
        .soft_req (soft_req)
    );

    tmr_supervisor #(
        .DATA_W (DATA_W)
    ) u_sup (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_hit  (sup_hit),
        .soft_req (soft_req),
        .cpu_data (cpu_data),
        .reg_q    (sup_q),
        .soft_rst (serial_soft_rst)
    );

    assign sel = mode_to_sel(sup_q.mode);

    tmr_wr_gate u_gate (
        .rom_hit (rom_hit),
        .sel     (sel),
        .we      (we)
    );

    assign latch_we  = we[SEL_LATCH];
    assign scan_we   = we[SEL_SCAN];
    assign serial_we = we[SEL_SERIAL];

    tmr_route #(
        .PRG_W           (PRG_W),
        .CHR_LO_W        (CHR_LO_W),
        .A18_FROM_SERIAL (A18_FROM_SERIAL)
    ) u_route (
        .sel        (sel),
        .base       (sup_q.base),
        .latch_prg  (latch_prg),
        .latch_chr  (latch_chr),
        .latch_irq  (latch_irq),
        .scan_prg   (scan_prg),
        .scan_chr   (scan_chr),
        .scan_irq   (scan_irq),
        .serial_prg (serial_prg),
        .serial_chr (serial_chr),
        .serial_irq (serial_irq),
        .prg_addr   (prg_addr),
        .chr_addr   (chr_addr),
        .irq_out    (irq_out)
    );

endmodule

// File: rtl/tmr_router_chk.sv
module tmr_router_chk #(
    parameter int ADDR_W          = 16,
    parameter int SEL_BIT         = 8,
    parameter bit A18_FROM_SERIAL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              latch_we,
    input logic              scan_we,
    input logic              serial_we,
    input logic              soft_rst,
    input logic              chr_top,
    input logic              serial_top,
    input logic              irq_out,
    input logic              latch_irq,
    input logic              scan_irq,
    input logic              serial_irq,
    input logic [1:0]        mode,
    input logic              base
);
    logic hit;
    assign hit = cpu_wr && (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b01) && cpu_addr[SEL_BIT];

    p_we_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({latch_we, scan_we, serial_we}));

    p_we_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_we || scan_we || serial_we) |-> (cpu_wr && cpu_addr[ADDR_W-1]));

    p_we_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |-> (mode == 2'b00));

    p_we_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_we |-> (mode == 2'b01));

    p_we_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        serial_we |-> mode[1]);

    p_irq_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (irq_out == latch_irq));

    p_irq_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> (irq_out == scan_irq));

    p_irq_serial_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (irq_out == serial_irq));

    p_a18_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> (chr_top == base));

    p_a18_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (chr_top == (A18_FROM_SERIAL ? serial_top : base)));

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(hit && cpu_addr[0]));

    p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(mode) && $stable(base)));

endmodule

bind tri_mapper_router tmr_router_chk #(
    .ADDR_W          (ADDR_W),
    .SEL_BIT         (SEL_BIT),
    .A18_FROM_SERIAL (A18_FROM_SERIAL)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .latch_we   (latch_we),
    .scan_we    (scan_we),
    .serial_we  (serial_we),
    .soft_rst   (serial_soft_rst),
    .chr_top    (chr_addr[CHR_LO_W]),
    .serial_top (serial_chr[CHR_LO_W]),
    .irq_out    (irq_out),
    .latch_irq  (latch_irq),
    .scan_irq   (scan_irq),
    .serial_irq (serial_irq),
    .mode       (sup_q.mode),
    .base       (sup_q.base)
);

// File: tb/tri_mapper_router_tb_top.sv
`timescale 1ns/1ps

module tmr_stub #(
    parameter logic [10:0] ID      = 11'h0,
    parameter int          CW      = 18,
    parameter logic [7:0]  RST_VAL = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          clr,
    input  logic [7:0]    d,
    output logic [18:0]   prg,
    output logic [CW-1:0] chr,
    output logic          irq
);
    logic [7:0] r_q;
    always_ff @(posedge clk) begin
        if (!rst_n)   r_q <= RST_VAL;
        else if (clr) r_q <= 8'h00;
        else if (we)  r_q <= d;
    end
    assign prg = {ID, r_q};
    assign chr = CW'({ID, r_q});
    assign irq = r_q[7];
endmodule

module tri_mapper_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        latch_we, scan_we, serial_we, serial_soft_rst;
    logic [18:0] latch_prg, scan_prg, serial_prg, prg_addr;
    logic [17:0] latch_chr, scan_chr;
    logic [18:0] serial_chr, chr_addr;
    logic        latch_irq, scan_irq, serial_irq, irq_out;

    always #4 clk = ~clk;

    localparam logic [10:0] ID0 = 11'h1C5;
    localparam logic [10:0] ID1 = 11'h2B6;
    localparam logic [10:0] ID2 = 11'h5A3;

    tmr_stub #(.ID(ID0), .CW(18), .RST_VAL(8'hFF)) stub0 (
        .clk(clk), .rst_n(rst_n), .we(latch_we), .clr(1'b0), .d(cpu_data),
        .prg(latch_prg), .chr(latch_chr), .irq(latch_irq));
    tmr_stub #(.ID(ID1), .CW(18), .RST_VAL(8'h00)) stub1 (
        .clk(clk), .rst_n(rst_n), .we(scan_we), .clr(1'b0), .d(cpu_data),
        .prg(scan_prg), .chr(scan_chr), .irq(scan_irq));
    tmr_stub #(.ID(ID2), .CW(19), .RST_VAL(8'h00)) stub2 (
        .clk(clk), .rst_n(rst_n), .we(serial_we), .clr(serial_soft_rst), .d(cpu_data),
        .prg(serial_prg), .chr(serial_chr), .irq(serial_irq));

    tri_mapper_router dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .latch_we(latch_we), .scan_we(scan_we), .serial_we(serial_we),
        .serial_soft_rst(serial_soft_rst),
        .latch_prg(latch_prg), .latch_chr(latch_chr), .latch_irq(latch_irq),
        .scan_prg(scan_prg), .scan_chr(scan_chr), .scan_irq(scan_irq),
        .serial_prg(serial_prg), .serial_chr(serial_chr), .serial_irq(serial_irq),
        .prg_addr(prg_addr), .chr_addr(chr_addr), .irq_out(irq_out));

    typedef struct {
        int          id;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;

    // bench model
    logic [1:0]  m_mode = 2'b00;
    logic        m_base = 1'b0;
    logic [7:0]  m_val [3] = '{8'hFF, 8'h00, 8'h00};
    logic [10:0] m_id  [3] = '{ID0, ID1, ID2};

    function automatic int sel_of(input logic [1:0] m);
        return (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
    endfunction

    function automatic logic [31:0] observe(input int id);
        case (id)
            0:       return {29'd0, serial_we, scan_we, latch_we};
            1:       return {13'd0, prg_addr};
            2:       return {13'd0, chr_addr};
            3:       return {31'd0, irq_out};
            default: return {31'd0, serial_soft_rst};
        endcase
    endfunction

    task automatic push(input int id, input logic [31:0] exp, input string req);
        item_t it;
        it.id = id; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic push_route(input string req);
        int s;
        logic [18:0] c;
        s = sel_of(m_mode);
        if (s == 2) c = {m_id[2], m_val[2]};
        else        c = {m_base, m_id[s][9:0], m_val[s]};
        push(1, {13'd0, m_id[s], m_val[s]}, req);
        push(2, {13'd0, c}, req);
        push(3, {31'd0, m_val[s][7]}, req);
    endtask

    // monitor: pops expectations and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = observe(it.id);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.id, act, it.exp);
                end
            end
        end
    end

    task automatic sup_write(input logic [15:0] a, input logic [7:0] d, input string req);
        bit hit, pulse;
        hit   = (a[15:14] == 2'b01) && a[8];
        pulse = hit && a[0];
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        push_route({req, " R11 old setting during write"});
        push(0, 32'd0, {req, " R5 no enable below 8000"});
        @(negedge clk);
        cpu_wr = 1'b0;
        if (hit) begin
            m_mode = d[1:0];
            m_base = d[2];
        end
        push_route({req, " R11 R4 R6 new setting next cycle"});
        push(4, {31'd0, pulse}, {req, " R10 pulse"});
        @(negedge clk);
        if (pulse) m_val[2] = 8'h00;
        push_route({req, " R6 R7 after write"});
        push(4, 32'd0, {req, " R10 pulse ended"});
    endtask

    task automatic core_write(input logic [15:0] a, input logic [7:0] d, input string req);
        int s;
        s = sel_of(m_mode);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        push(0, 32'd1 << s, {req, " R5 enable of selected core"});
        @(negedge clk);
        cpu_wr = 1'b0;
        m_val[s] = d;
        push_route({req, " R6 R7 core routed"});
        push(0, 32'd0, {req, " R5 enable released"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_route("R1 reset routes latch core with base 0");
        push(0, 32'd0, "R1 no enable after reset");
        push(4, 32'd0, "R1 no pulse after reset");

        core_write(16'h8000, 8'h12, "R5 latch core canonical");
        core_write(16'hE123, 8'h34, "R5 latch core mirror");
        sup_write(16'h6000, 8'h01, "R2 6000 ignored");
        sup_write(16'h4000, 8'h01, "R2 4000 ignored");
        sup_write(16'h4100, 8'hF9, "R3 upper data bits ignored, scan mode");
        core_write(16'hA000, 8'h9C, "R7 scan core irq high");
        sup_write(16'h5100, 8'h04, "R8 latch with base 1");
        core_write(16'h9FFF, 8'h56, "R6 latch keeps then updates");
        sup_write(16'h4180, 8'h03, "R4 mode 11 serial");
        core_write(16'hC000, 8'hA5, "R9 serial core top bit");
        sup_write(16'h7FFF, 8'h06, "R10 pulse with mode 10 base 1");
        sup_write(16'h4101, 8'h01, "R10 pulse in scan mode");
        core_write(16'hFFFF, 8'h11, "R7 scan core irq low");
        sup_write(16'h41FE, 8'h05, "R8 scan base 1 no pulse");
        sup_write(16'h4200, 8'h00, "R2 bit8 clear ignored");
        core_write(16'h8001, 8'h80, "R6 scan core second write");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            $display("FAIL all requirements: watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule